// File: doc/BRIEF.md
# Down-Counting Raster Timing Generator

This block produces the horizontal and vertical sync, blanking and active-video strobes for a display driven at one pixel per clock. A pixel counter counts down from a programmed pixel total to zero, and on each wrap it reloads and steps a line counter down, which counts from the line total to zero. Each strobe is a window: it is high while its counter lies between a programmed start value and a lower stop value, with both ends included. The combined active-video output is high where the horizontal and vertical active windows overlap.

Software programs the block through a small register bus. All timing and control registers are guarded by a one-shot key. Writing the key value to the key register unlocks the bank for the next bus access only. New values are held in shadow registers and copied into the working set at the next frame boundary. A frame is made of (pixel total + 1) x (line total + 1) clocks. Clearing the enable bit blanks every strobe and holds both counters at their totals. Setting it again restarts scanning from the top of a frame. The 16-bit counters cover every mode from 64x64 up to 1024x768, margins included.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset all strobe outputs are low, the enable bit (register 0, bit 0) reads 0, the pixel total (register 1) reads DEF_HTOT and the line total (register 2) reads DEF_VTOT.
- R2: While enabled, a line lasts pixel total + 1 clocks, so hsync rises once every pixel total + 1 clocks.
- R3: A frame lasts (pixel total + 1) x (line total + 1) clocks, so vsync rises once per frame.
- R4: A window register holds its start count in bits 15:0 and its stop count in bits 31:16. Its strobe is high while stop <= count <= start. Registers 3, 4 and 5 are the hsync, hblank and hactive windows on the pixel count. Registers 6, 7 and 8 are the vsync, vblank and vactive windows on the line count.
- R5: active_o is high exactly where both the hactive and vactive windows hold.
- R6: hblank_o and vblank_o follow their own windows independently of the sync and active windows.
- R7: Writing 0xAA to the key register (address 15) unlocks the bank, and the very next write to a register 0 to 8 is accepted and reads back.
- R8: A write to registers 0 to 8 without a preceding unlock is ignored: readback and timing are unchanged.
- R9: Any bus access other than a key write relocks the bank, so a read placed between the key and a write makes that write ignored.
- R10: Accepted changes to totals and windows take effect only at the next frame start. The frame in progress keeps the old timing.
- R11: Clearing the enable bit drives all strobes low one clock later. Setting it again restarts at the top of a frame, with hsync and vsync high one clock after the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| hsync_o | output | 1 | Horizontal sync strobe |
| vsync_o | output | 1 | Vertical sync strobe |
| hblank_o | output | 1 | Horizontal blanking strobe |
| vblank_o | output | 1 | Vertical blanking strobe |
| active_o | output | 1 | Active video, the overlap of both active windows |

## Verification
The assertions assume that a read strobe and a write strobe are never high in the same cycle. They also assume that every window start lies at or below its counter's total, so each strobe can fire within a line or frame. The bench drives one access per task call, with the strobe held for exactly one clock, and programs only window values inside the totals it has set. Timing checks count rising edges and high cycles over whole lines and frames. This keeps them independent of the phase at which a measurement begins.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int NWIN   = 6;

  // window slots; the first three compare against the pixel count
  localparam int W_HSYNC  = 0;
  localparam int W_HBLANK = 1;
  localparam int W_HACT   = 2;
  localparam int W_VSYNC  = 3;
  localparam int W_VBLANK = 4;
  localparam int W_VACT   = 5;
  localparam int NHWIN    = 3;

  // register addresses
  localparam int A_CTRL = 0;
  localparam int A_HTOT = 1;
  localparam int A_VTOT = 2;
  localparam int A_WIN0 = 3;
  localparam int A_KEY  = 15;

  localparam logic [DATA_W-1:0] KEY_VALUE = 32'h0000_00AA;

  typedef struct packed {
    logic [CNT_W-1:0] stop;
    logic [CNT_W-1:0] start;
  } win_t;

  typedef struct packed {
    logic             en;
    logic [CNT_W-1:0] htot;
    logic [CNT_W-1:0] vtot;
    win_t [NWIN-1:0]  win;
  } cfg_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DEF_HTOT = 799,
  parameter int DEF_VTOT = 524
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output cfg_t              cfg
);
  logic unl_q;
  logic acc, key_hit, is_key;
  logic [DATA_W-1:0] rd_val;

  assign acc     = wr | rd;
  assign is_key  = (addr == ADDR_W'(A_KEY));
  assign key_hit = wr && is_key && (wdata == KEY_VALUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      unl_q    <= 1'b0;
      cfg.en   <= 1'b0;
      cfg.htot <= CNT_W'(DEF_HTOT);
      cfg.vtot <= CNT_W'(DEF_VTOT);
      cfg.win  <= '0;
    end else begin
      if (acc) unl_q <= key_hit;
      if (wr && unl_q && !is_key) begin
        if (addr == ADDR_W'(A_CTRL)) cfg.en   <= wdata[0];
        if (addr == ADDR_W'(A_HTOT)) cfg.htot <= wdata[CNT_W-1:0];
        if (addr == ADDR_W'(A_VTOT)) cfg.vtot <= wdata[CNT_W-1:0];
        for (int i = 0; i < NWIN; i++)
          if (addr == ADDR_W'(A_WIN0 + i)) cfg.win[i] <= wdata;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr == ADDR_W'(A_CTRL)) rd_val = DATA_W'(cfg.en);
    if (addr == ADDR_W'(A_HTOT)) rd_val = DATA_W'(cfg.htot);
    if (addr == ADDR_W'(A_VTOT)) rd_val = DATA_W'(cfg.vtot);
    if (is_key)                  rd_val = DATA_W'(unl_q);
    for (int i = 0; i < NWIN; i++)
      if (addr == ADDR_W'(A_WIN0 + i)) rd_val = cfg.win[i];
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_val;
  end

  // R7
  unlock_chk: assert property (@(posedge clk) disable iff (rst)
    key_hit |=> unl_q);
  // R9
  relock_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !key_hit) |=> !unl_q);
  // R8
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !unl_q) |=> $stable(cfg));
endmodule

// File: rtl/rtg_cnt.sv
module rtg_cnt
  import rtg_pkg::*;
#(
  parameter int DEF_HTOT = 799,
  parameter int DEF_VTOT = 524
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] sh_htot,
  input  logic [CNT_W-1:0] sh_vtot,
  input  logic [CNT_W-1:0] act_htot,
  output logic [CNT_W-1:0] pix,
  output logic [CNT_W-1:0] line,
  output logic             load
);
  // a new frame begins when disabled or when both counts reach zero
  assign load = !en || (pix == '0 && line == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix  <= CNT_W'(DEF_HTOT);
      line <= CNT_W'(DEF_VTOT);
    end else if (load) begin
      pix  <= sh_htot;
      line <= sh_vtot;
    end else if (pix == '0) begin
      pix  <= act_htot;
      line <= line - 1'b1;
    end else begin
      pix  <= pix - 1'b1;
    end
  end

  // R2
  pix_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pix != '0) |=> (pix == $past(pix) - 1'b1));
  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pix == '0 && line != '0) |=> (line == $past(line) - 1'b1));
endmodule

// File: rtl/rtg_win.sv
module rtg_win
  import rtg_pkg::*;
(
  input  logic [CNT_W-1:0] cnt,
  input  win_t             win,
  output logic             hit
);
  assign hit = (cnt <= win.start) && (cnt >= win.stop);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DEF_HTOT = 799,
  parameter int DEF_VTOT = 524
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              active_o
);
  cfg_t sh_cfg, act_cfg;
  logic [CNT_W-1:0] pix, line;
  logic load;
  logic [NWIN-1:0] hit;

  rtg_regs #(.ADDR_W(ADDR_W), .DEF_HTOT(DEF_HTOT), .DEF_VTOT(DEF_VTOT)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .cfg(sh_cfg));

  rtg_cnt #(.DEF_HTOT(DEF_HTOT), .DEF_VTOT(DEF_VTOT)) u_cnt (
    .clk(clk), .rst(rst), .en(sh_cfg.en), .sh_htot(sh_cfg.htot),
    .sh_vtot(sh_cfg.vtot), .act_htot(act_cfg.htot),
    .pix(pix), .line(line), .load(load));

  // working copy, refreshed only at frame start
  always_ff @(posedge clk) begin
    if (rst)       act_cfg <= '0;
    else if (load) act_cfg <= sh_cfg;
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    rtg_win u_win (
      .cnt(g < NHWIN ? pix : line),
      .win(act_cfg.win[g]),
      .hit(hit[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o  <= 1'b0;
      vsync_o  <= 1'b0;
      hblank_o <= 1'b0;
      vblank_o <= 1'b0;
      active_o <= 1'b0;
    end else begin
      hsync_o  <= sh_cfg.en & hit[W_HSYNC];
      vsync_o  <= sh_cfg.en & hit[W_VSYNC];
      hblank_o <= sh_cfg.en & hit[W_HBLANK];
      vblank_o <= sh_cfg.en & hit[W_VBLANK];
      active_o <= sh_cfg.en & hit[W_HACT] & hit[W_VACT];
    end
  end

  // R11
  off_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !sh_cfg.en |=> !(hsync_o | vsync_o | hblank_o | vblank_o | active_o));
  // R10
  frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act_cfg));
endmodule

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
  localparam int AW = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic wr = 0, rd = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic hs, vs, hb, vb, act;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  raster_timing_gen uut (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .hsync_o(hs), .vsync_o(vs),
    .hblank_o(hb), .vblank_o(vb), .active_o(act));

  task automatic chk(input bit ok, input string req, input int a, input int e);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = AW'(a);
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic key_wr(input int a, input logic [31:0] d);
    bus_wr(15, 32'hAA);
    bus_wr(a, d);
  endtask

  function automatic logic sig(input int s);
    case (s)
      0: return hs;
      1: return vs;
      2: return hb;
      3: return vb;
      default: return act;
    endcase
  endfunction

  // returns at the first negedge where the signal is seen rising
  task automatic wait_rise(input int s);
    logic prev = sig(s);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (sig(s) && !prev) return;
      prev = sig(s);
    end
  endtask

  task automatic period(input int s, output int p);
    wait_rise(s);
    p = 0;
    begin
      logic prev = sig(s);
      for (int i = 0; i < 5000; i++) begin
        @(negedge clk); p++;
        if (sig(s) && !prev) break;
        prev = sig(s);
      end
    end
  endtask

  task automatic highs(input int s, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sig(s)) c++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(!(hs|vs|hb|vb|act), "R1 outputs", int'({hs,vs,hb,vb,act}), 0);
    bus_rd(0, d); chk(d == 0, "R1 enable", d, 0);
    bus_rd(1, d); chk(d == 799, "R1 htot", d, 799);
    bus_rd(2, d); chk(d == 524, "R1 vtot", d, 524);
  endtask

  task automatic t_program;
    logic [31:0] d;
    key_wr(1, 19); key_wr(2, 9);
    key_wr(3, 32'h0010_0013); key_wr(4, 32'h0002_000E);
    key_wr(5, 32'h0002_000E); key_wr(6, 32'h0008_0009);
    key_wr(7, 32'h0001_0006); key_wr(8, 32'h0001_0006);
    bus_rd(1, d); chk(d == 19, "R7 htot accepted", d, 19);
    bus_rd(6, d); chk(d == 32'h0008_0009, "R7 window accepted", d, 32'h0008_0009);
    key_wr(0, 1);
    bus_rd(0, d); chk(d == 1, "R7 enable accepted", d, 1);
  endtask

  task automatic t_periods;
    int p;
    period(0, p); chk(p == 20, "R2 line period", p, 20);
    period(1, p); chk(p == 200, "R3 frame period", p, 200);
  endtask

  task automatic t_windows;
    int c;
    highs(0, 200, c); chk(c == 40, "R4 hsync per frame", c, 40);
    highs(1, 200, c); chk(c == 40, "R4 vsync per frame", c, 40);
    highs(2, 200, c); chk(c == 130, "R6 hblank per frame", c, 130);
    highs(3, 200, c); chk(c == 120, "R6 vblank per frame", c, 120);
    highs(4, 200, c); chk(c == 78, "R5 active per frame", c, 78);
  endtask

  task automatic t_nokey;
    logic [31:0] d; int p;
    bus_wr(1, 29);
    bus_rd(1, d); chk(d == 19, "R8 readback", d, 19);
    wait_rise(1); wait_rise(1);
    period(0, p); chk(p == 20, "R8 timing", p, 20);
  endtask

  task automatic t_consume;
    logic [31:0] d;
    bus_wr(15, 32'hAA);
    bus_rd(0, d);
    bus_wr(1, 29);
    bus_rd(1, d); chk(d == 19, "R9 relocked", d, 19);
  endtask

  task automatic t_frame;
    int p;
    wait_rise(1);
    key_wr(1, 29);
    period(0, p); chk(p == 20, "R10 old frame kept", p, 20);
    wait_rise(1);
    period(0, p); chk(p == 30, "R10 new frame", p, 30);
    key_wr(1, 19);
    wait_rise(1);
    period(1, p); chk(p == 200, "R10 restored frame", p, 200);
  endtask

  task automatic t_disable;
    int c = 0;
    key_wr(0, 0);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (hs|vs|hb|vb|act) c++;
    end
    chk(c == 0, "R11 blanked", c, 0);
    key_wr(0, 1);
    chk(!vs, "R11 still low at write", vs, 0);
    @(negedge clk);
    chk(vs && hs, "R11 restart at top", int'({vs,hs}), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_program;
    t_periods;
    t_windows;
    t_nokey;
    t_consume;
    t_frame;
    t_disable;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule